// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

The controller turns single-word requests from a clocked valid/ready interface into correctly timed access cycles on an external asynchronous 16-bit static RAM. Each request carries a word address, a write flag, write data and two byte enables. The controller drives the memory's address lines, the two chip enables (one active low and one active high), the write strobe, the output enable and the two byte-lane selects. It also drives the data bus through separate output, output-enable and input signals, so that the three-state buffer can sit at the pad.

Every access is a fixed sequence of registered states. A wait counter holds each phase for a number of system clocks. Each count is derived at elaboration from a timing value in nanoseconds and the clock period. The derived counts set the read hold time, the write strobe width and the recovery gap after a read, during which the memory releases the bus. Read data is captured on the last clock of the read phase and returned with a one-cycle valid pulse. A new request is taken only after the whole access cycle has finished.

Top module: `asram_ctrl`

## Requirements
- R1: After reset, and whenever `req_ready` is high, the memory is deselected (`sram_ce_n`=1, `sram_ce`=0), `sram_we_n`=1, `sram_oe_n`=1, `sram_ub_n`=`sram_lb_n`=1, `sram_dq_oe`=0 and `rsp_valid`=0. After reset `req_ready` is 1.
- R2: A write holds `sram_we_n` low for exactly W_CYC clocks, where W_CYC is the largest of the strobe-width, address-to-end and data-to-end counts. Address, chip enables, byte selects and driven data assert on the edge where `sram_we_n` falls and stay constant until it rises. `sram_oe_n` stays high for the whole write.
- R3: `sram_lb_n` is low only if `req_be[0]` is set (data bits 7..0), and `sram_ub_n` is low only if `req_be[1]` is set (bits 15..8), for reads and for writes. A write leaves the stored byte of a lane that is not enabled unchanged, so a write with `req_be`=00 changes nothing.
- R4: A read holds `sram_oe_n` low for exactly RD_CYC clocks, the larger of the read-cycle and output-enable counts, with address, chip enables and byte selects held. `sram_dq_oe` stays low meanwhile, and `sram_dq_in` is captured on the final clock edge of that phase.
- R5: `rsp_valid` is high for exactly one cycle, RD_CYC clock edges after the edge that accepted the read. It is never raised for a write. `rsp_rdata` carries the captured word, with the lanes that were not enabled forced to zero.
- R6: After `sram_oe_n` rises, the memory stays deselected for HZ_CYC clocks, the count for the bus-release time. `sram_dq_oe` does not assert within HZ_CYC clocks of the rise of `sram_oe_n`.
- R7: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high, and `req_ready` then drops. `req_ready` returns RD_CYC+HZ_CYC edges after a read is accepted, and W_CYC+WREC_CYC edges after a write is accepted, where WREC_CYC = max(1, RC_CYC − W_CYC). During that recovery the memory is deselected.
- R8: Each count equals ceil(time_ns / CLK_NS), with a minimum of one. The defaults (8 ns clock; 70/25/40/50/40/20 ns) give RC_CYC=9, RD_CYC=9, W_CYC=7, WREC_CYC=2 and HZ_CYC=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_addr | input | ADDR_W | Word address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write data |
| req_be | input | 2 | Byte enables, bit 0 = bits 7..0, bit 1 = bits 15..8 |
| rsp_valid | output | 1 | One-cycle read-data pulse |
| rsp_rdata | output | DATA_W | Read data, disabled lanes zero |
| sram_addr | output | ADDR_W | Memory address |
| sram_ce_n | output | 1 | Active-low chip enable |
| sram_ce | output | 1 | Active-high chip enable |
| sram_we_n | output | 1 | Active-low write strobe |
| sram_oe_n | output | 1 | Active-low output enable |
| sram_ub_n | output | 1 | Active-low upper byte select |
| sram_lb_n | output | 1 | Active-low lower byte select |
| sram_dq_out | output | DATA_W | Data toward the memory |
| sram_dq_oe | output | 1 | Drive enable for sram_dq_out |
| sram_dq_in | input | DATA_W | Data from the memory |

## Verification
The bench builds the controller with a 6-bit address, giving a 64-word memory, and keeps the default nanosecond timings at an 8 ns clock. With that depth it can write and read back every word, then step through all four byte-enable codes on writes and reads in alternation. The alternation puts every read-to-write and write-to-read turnaround on the bus. A behavioural memory model in the bench measures strobe width, address and data setup, the output-valid delay and the 20 ns release window in time units. The bench derives every expected cycle count from the same nanosecond figures by its own arithmetic.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
package asram_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2,
    ST_REC  = 2'd3
  } asram_state_t;

  // Clock cycles needed to cover t_ns, never fewer than one.
  function automatic int unsigned cyc_of(input int unsigned t_ns,
                                         input int unsigned clk_ns);
    int unsigned c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int unsigned umax(input int unsigned a,
                                       input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_timer.sv
`timescale 1ns/1ps
// Loadable down-counter that marks the last cycle of a phase.
module asram_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/asram_lanes.sv
`timescale 1ns/1ps
// Maps byte enables to active-low lane selects.
module asram_lanes #(
  parameter int LANES = 2
) (
  input  logic [LANES-1:0] be,
  output logic [LANES-1:0] sel_n
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign sel_n[i] = ~be[i];
  end
endmodule

// File: rtl/asram_rcap.sv
`timescale 1ns/1ps
// Read-data capture register, zeroing lanes that were not requested.
module asram_rcap #(
  parameter int DATA_W = 16,
  parameter int LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [LANES-1:0]  mask,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        dout[i*8 +: 8] <= 8'h00;
      end else if (capture) begin
        dout[i*8 +: 8] <= mask[i] ? din[i*8 +: 8] : 8'h00;
      end
    end
  end
endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/1ps
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int DATA_W    = 16,
  parameter int CLK_NS    = 8,
  parameter int T_RC_NS   = 70,
  parameter int T_OE_NS   = 25,
  parameter int T_WP_NS   = 40,
  parameter int T_AW_NS   = 50,
  parameter int T_DW_NS   = 40,
  parameter int T_HZ_NS   = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_be,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce_n,
  output logic              sram_ce,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic              sram_ub_n,
  output logic              sram_lb_n,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_in
);
  localparam int LANES    = 2;
  localparam int RC_CYC   = int'(cyc_of(T_RC_NS, CLK_NS));
  localparam int OE_CYC   = int'(cyc_of(T_OE_NS, CLK_NS));
  localparam int WP_CYC   = int'(cyc_of(T_WP_NS, CLK_NS));
  localparam int AW_CYC   = int'(cyc_of(T_AW_NS, CLK_NS));
  localparam int DW_CYC   = int'(cyc_of(T_DW_NS, CLK_NS));
  localparam int HZ_CYC   = int'(cyc_of(T_HZ_NS, CLK_NS));
  localparam int RD_CYC   = int'(umax(RC_CYC, OE_CYC));
  localparam int W_CYC    = int'(umax(umax(WP_CYC, AW_CYC), DW_CYC));
  localparam int WREC_CYC = (RC_CYC > W_CYC) ? (RC_CYC - W_CYC) : 1;
  localparam int MAX_CYC  = int'(umax(umax(RD_CYC, W_CYC), umax(HZ_CYC, WREC_CYC)));
  localparam int CNT_W    = $clog2(MAX_CYC + 1);

  asram_state_t      state;
  logic              t_zero;
  logic              t_load;
  logic [CNT_W-1:0]  t_val;
  logic [LANES-1:0]  lane_sel_n;
  logic [LANES-1:0]  rd_mask;
  logic              accept;
  logic              rd_done;
  logic              wr_done;

  assign accept  = (state == ST_IDLE) && req_valid && req_ready;
  assign rd_done = (state == ST_RD) && t_zero;
  assign wr_done = (state == ST_WR) && t_zero;

  asram_lanes #(.LANES(LANES)) lanes_i (
    .be    (req_be),
    .sel_n (lane_sel_n)
  );

  // Phase length selection for the wait counter.
  always_comb begin
    t_load = accept || rd_done || wr_done;
    t_val  = '0;
    if (accept) begin
      t_val = req_write ? CNT_W'(W_CYC - 1) : CNT_W'(RD_CYC - 1);
    end else if (rd_done) begin
      t_val = CNT_W'(HZ_CYC - 1);
    end else if (wr_done) begin
      t_val = CNT_W'(WREC_CYC - 1);
    end
  end

  asram_timer #(.CNT_W(CNT_W)) timer_i (
    .clk      (clk),
    .rst      (rst),
    .load     (t_load),
    .load_val (t_val),
    .zero     (t_zero)
  );

  asram_rcap #(.DATA_W(DATA_W), .LANES(LANES)) rcap_i (
    .clk     (clk),
    .rst     (rst),
    .capture (rd_done),
    .mask    (rd_mask),
    .din     (sram_dq_in),
    .dout    (rsp_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      req_ready   <= 1'b1;
      rsp_valid   <= 1'b0;
      sram_addr   <= '0;
      sram_ce_n   <= 1'b1;
      sram_ce     <= 1'b0;
      sram_we_n   <= 1'b1;
      sram_oe_n   <= 1'b1;
      sram_ub_n   <= 1'b1;
      sram_lb_n   <= 1'b1;
      sram_dq_out <= '0;
      sram_dq_oe  <= 1'b0;
      rd_mask     <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            req_ready <= 1'b0;
            sram_addr <= req_addr;
            sram_ce_n <= 1'b0;
            sram_ce   <= 1'b1;
            sram_ub_n <= lane_sel_n[1];
            sram_lb_n <= lane_sel_n[0];
            rd_mask   <= req_be;
            if (req_write) begin
              sram_we_n   <= 1'b0;
              sram_dq_out <= req_wdata;
              sram_dq_oe  <= 1'b1;
              state       <= ST_WR;
            end else begin
              sram_oe_n <= 1'b0;
              state     <= ST_RD;
            end
          end
        end
        ST_RD: begin
          if (t_zero) begin
            rsp_valid <= 1'b1;
            sram_oe_n <= 1'b1;
            sram_ce_n <= 1'b1;
            sram_ce   <= 1'b0;
            sram_ub_n <= 1'b1;
            sram_lb_n <= 1'b1;
            state     <= ST_REC;
          end
        end
        ST_WR: begin
          if (t_zero) begin
            sram_we_n  <= 1'b1;
            sram_dq_oe <= 1'b0;
            sram_ce_n  <= 1'b1;
            sram_ce    <= 1'b0;
            sram_ub_n  <= 1'b1;
            sram_lb_n  <= 1'b1;
            state      <= ST_REC;
          end
        end
        ST_REC: begin
          if (t_zero) begin
            req_ready <= 1'b1;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/asram_ctrl_chk.sv
`timescale 1ns/1ps
module asram_ctrl_chk #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16,
  parameter int HZ_CYC = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] sram_addr,
  input logic              sram_ce_n,
  input logic              sram_ce,
  input logic              sram_we_n,
  input logic              sram_oe_n,
  input logic [DATA_W-1:0] sram_dq_out,
  input logic              sram_dq_oe
);
  // Clocks since output enable was last low, saturating at HZ_CYC.
  int gap_cnt;
  always_ff @(posedge clk) begin
    if (rst) gap_cnt <= HZ_CYC;
    else if (!sram_oe_n) gap_cnt <= 0;
    else if (gap_cnt < HZ_CYC) gap_cnt <= gap_cnt + 1;
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (sram_ce_n && !sram_ce && sram_we_n && sram_oe_n && !sram_dq_oe && !rsp_valid));

  // R2
  no_oe_in_write_chk: assert property (@(posedge clk) disable iff (rst)
    !sram_we_n |-> sram_oe_n);

  // R2
  wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!sram_we_n && $past(!sram_we_n)) |-> ($stable(sram_addr) && $stable(sram_dq_out) && !sram_ce_n));

  // R4
  no_drive_in_read_chk: assert property (@(posedge clk) disable iff (rst)
    !sram_oe_n |-> !sram_dq_oe);

  // R5
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R6
  hz_gap_chk: assert property (@(posedge clk) disable iff (rst)
    sram_dq_oe |-> (gap_cnt >= HZ_CYC));

  // R7
  accept_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
endmodule

bind asram_ctrl asram_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .HZ_CYC (HZ_CYC)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .rsp_valid   (rsp_valid),
  .sram_addr   (sram_addr),
  .sram_ce_n   (sram_ce_n),
  .sram_ce     (sram_ce),
  .sram_we_n   (sram_we_n),
  .sram_oe_n   (sram_oe_n),
  .sram_dq_out (sram_dq_out),
  .sram_dq_oe  (sram_dq_oe)
);

// File: tb/asram_model.sv
`timescale 1ns/1ps
// Behavioural asynchronous SRAM with timing and contention checks.
module asram_model #(
  parameter int AW = 6
) (
  input  logic [AW-1:0] addr,
  input  logic          ce_n,
  input  logic          ce,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic          ub_n,
  input  logic          lb_n,
  input  logic [15:0]   dq_out,
  input  logic          dq_oe,
  output logic [15:0]   dq_in,
  output int            viol
);
  logic [15:0] mem [0:(1<<AW)-1];
  longint t_addr, t_sel, t_oe, t_wef, t_din, drive_until;
  logic [AW-1:0] p_addr;
  logic p_sel, p_oe_n, p_we_n, p_dq_oe;
  logic [15:0] p_dq_out;
  logic wl_act, wl_dok;
  logic [1:0] wl_lanes;
  logic [15:0] wl_data;
  logic [AW-1:0] wl_addr;

  initial begin
    for (int i = 0; i < (1<<AW); i++) mem[i] = 16'h0000;
    viol = 0; t_addr = 0; t_sel = 0; t_oe = 0; t_wef = 0; t_din = 0;
    drive_until = 0; p_addr = '0; p_sel = 0; p_oe_n = 1; p_we_n = 1;
    p_dq_oe = 0; p_dq_out = 0; wl_act = 0; wl_dok = 0; wl_lanes = 0;
    wl_data = 0; wl_addr = '0; dq_in = 16'hFFFF;
  end

  always #1 begin : poll
    longint now;
    logic sel, drv;
    now = longint'($time);
    sel = !ce_n && ce && (!ub_n || !lb_n);
    // end of write strobe: check with stamps from before this instant
    if (we_n && !p_we_n && wl_act) begin
      if (now - t_wef < 40) begin viol++; $display("model: strobe short %0d", now - t_wef); end
      if (now - t_addr < 50) begin viol++; $display("model: address setup %0d", now - t_addr); end
      if (now - t_sel < 50) begin viol++; $display("model: select setup %0d", now - t_sel); end
      if (now - t_din < 40) begin viol++; $display("model: data setup %0d", now - t_din); end
      if (!wl_dok) begin viol++; $display("model: data not driven in write"); end
      if (wl_lanes[0]) mem[wl_addr][7:0]  = wl_data[7:0];
      if (wl_lanes[1]) mem[wl_addr][15:8] = wl_data[15:8];
      wl_act = 0;
    end
    if (addr != p_addr) begin
      if (!we_n && !p_we_n && sel) begin viol++; $display("model: address moved in write"); end
      t_addr = now;
    end
    if (sel && !p_sel) t_sel = now;
    if (!oe_n && p_oe_n) t_oe = now;
    if (!we_n && p_we_n) t_wef = now;
    if (dq_oe != p_dq_oe || dq_out != p_dq_out) t_din = now;
    if (!we_n && sel) begin
      wl_act = 1; wl_dok = dq_oe; wl_data = dq_out;
      wl_lanes = {~ub_n, ~lb_n}; wl_addr = addr;
    end
    drv = sel && !oe_n && we_n;
    if (drv) drive_until = now + 20;
    if ((drv || now < drive_until) && dq_oe) begin
      viol++; $display("model: bus contention at %0d", now);
    end
    if (drv && (now - t_addr >= 70) && (now - t_sel >= 70) && (now - t_oe >= 25)) begin
      dq_in[7:0]  = !lb_n ? mem[addr][7:0]  : 8'hA5;
      dq_in[15:8] = !ub_n ? mem[addr][15:8] : 8'hA5;
    end else if (drv || now < drive_until) begin
      dq_in = 16'hBAD0;
    end else begin
      dq_in = 16'hFFFF;
    end
    p_addr = addr; p_sel = sel; p_oe_n = oe_n; p_we_n = we_n;
    p_dq_oe = dq_oe; p_dq_out = dq_out;
  end
endmodule

// File: tb/asram_ctrl_tb_top.sv
`timescale 1ns/1ps
module asram_ctrl_tb_top;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int CLK = 8;

  function automatic int bceil(input int ns);
    int c;
    c = ns / CLK + ((ns % CLK) != 0 ? 1 : 0);
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int bmax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [1:0] req_be = 2'b00;
  logic req_ready, rsp_valid;
  logic [DW-1:0] rsp_rdata, sram_dq_out, sram_dq_in;
  logic [AW-1:0] sram_addr;
  logic sram_ce_n, sram_ce, sram_we_n, sram_oe_n, sram_ub_n, sram_lb_n, sram_dq_oe;
  int viol;

  asram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CLK_NS(CLK), .T_RC_NS(70), .T_OE_NS(25),
    .T_WP_NS(40), .T_AW_NS(50), .T_DW_NS(40), .T_HZ_NS(20)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sram_addr(sram_addr),
    .sram_ce_n(sram_ce_n), .sram_ce(sram_ce), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
    .sram_ub_n(sram_ub_n), .sram_lb_n(sram_lb_n), .sram_dq_out(sram_dq_out),
    .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in));

  asram_model #(.AW(AW)) mem_i (
    .addr(sram_addr), .ce_n(sram_ce_n), .ce(sram_ce), .we_n(sram_we_n), .oe_n(sram_oe_n),
    .ub_n(sram_ub_n), .lb_n(sram_lb_n), .dq_out(sram_dq_out), .dq_oe(sram_dq_oe),
    .dq_in(sram_dq_in), .viol(viol));

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Expected counts (R8)
  int e_rc, e_rd, e_w, e_hz, e_wrec;
  int n_chk = 0, n_fail = 0, n_reads = 0;
  int we_run = 0, we_len = 0, oe_run = 0, oe_len = 0, rsp_count = 0, rsp_cyc = -1;
  logic [DW-1:0] rsp_data = '0;
  logic [DW-1:0] shadow [0:(1<<AW)-1];

  always @(negedge clk) begin
    if (!sram_we_n) we_run++;
    else if (we_run != 0) begin we_len = we_run; we_run = 0; end
    if (!sram_oe_n) oe_run++;
    else if (oe_run != 0) begin oe_len = oe_run; oe_run = 0; end
    if (rsp_valid) begin rsp_count++; rsp_cyc = cyc; rsp_data = rsp_rdata; end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic [1:0] be, output logic [DW-1:0] rd);
    int acc, off;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    while (!req_ready) @(negedge clk);
    rsp_cyc = -1;
    @(posedge clk);
    @(negedge clk);
    acc = cyc;
    req_valid = 0;
    // R3 lane selects follow the byte enables
    check({sram_ub_n, sram_lb_n} == ~be, "R3", "lane selects", {sram_ub_n, sram_lb_n}, ~be);
    if (wr) check(!sram_we_n && sram_oe_n && sram_dq_oe && sram_addr == a, "R2",
                  "write strobe state", {sram_we_n, sram_oe_n, sram_dq_oe}, 3'b011);
    else    check(!sram_oe_n && sram_we_n && !sram_dq_oe && sram_addr == a, "R4",
                  "read strobe state", {sram_oe_n, sram_we_n, sram_dq_oe}, 3'b010);
    off = 0;
    while (!req_ready) begin
      if (sram_ce_n && !sram_ce) off++;
      @(negedge clk);
    end
    if (wr) begin
      check(cyc - acc == e_w + e_wrec, "R7", "write ready delay", cyc - acc, e_w + e_wrec);
      check(off == e_wrec, "R7", "write recovery deselect", off, e_wrec);
      check(we_len == e_w, "R2", "R8 strobe length", we_len, e_w);
      rd = '0;
    end else begin
      n_reads++;
      check(cyc - acc == e_rd + e_hz, "R7", "read ready delay", cyc - acc, e_rd + e_hz);
      check(off == e_hz, "R6", "release gap", off, e_hz);
      check(oe_len == e_rd, "R4", "R8 oe length", oe_len, e_rd);
      check(rsp_cyc == acc + e_rd, "R5", "response cycle", rsp_cyc - acc, e_rd);
      rd = rsp_data;
    end
  endtask

  function automatic logic [DW-1:0] pat(input int a);
    return DW'((a * 16'h0101) ^ 16'hC35A);
  endfunction

  function automatic logic [DW-1:0] lanes(input logic [DW-1:0] v, input logic [1:0] be);
    return {be[1] ? v[15:8] : 8'h00, be[0] ? v[7:0] : 8'h00};
  endfunction

  initial begin : watchdog
    #(CLK * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    logic [DW-1:0] r, nd;
    e_rc = bceil(70);
    e_rd = bmax(e_rc, bceil(25));
    e_w  = bmax(bmax(bceil(40), bceil(50)), bceil(40));
    e_hz = bceil(20);
    e_wrec = (e_rc > e_w) ? e_rc - e_w : 1;
    for (int i = 0; i < (1<<AW); i++) shadow[i] = '0;
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check(req_ready == 1, "R1", "ready after reset", req_ready, 1);
    check(sram_ce_n && !sram_ce, "R1", "chip deselected", {sram_ce_n, sram_ce}, 2'b10);
    check(sram_we_n && sram_oe_n, "R1", "strobes high", {sram_we_n, sram_oe_n}, 2'b11);
    check(sram_ub_n && sram_lb_n, "R1", "lanes off", {sram_ub_n, sram_lb_n}, 2'b11);
    check(!sram_dq_oe && !rsp_valid, "R1", "bus and response idle", {sram_dq_oe, rsp_valid}, 0);
    // R8 derived counts for the default timings
    check(e_rd == 9 && e_w == 7 && e_hz == 3 && e_wrec == 2, "R8", "derived counts",
          {e_rd[7:0], e_w[7:0], e_hz[7:0], e_wrec[7:0]}, 32'h09070302);

    // Full-word sweep: write all, read all
    for (int a = 0; a < (1<<AW); a++) begin
      access(1, AW'(a), pat(a), 2'b11, r);
      shadow[a] = pat(a);
    end
    for (int a = 0; a < (1<<AW); a++) begin
      access(0, AW'(a), '0, 2'b11, r);
      check(r == shadow[a], "R4", "full read data", r, shadow[a]);
    end
    // Byte-enable sweep with alternating write/read turnarounds
    for (int a = 0; a < 16; a++) begin
      for (int be = 0; be < 4; be++) begin
        nd = ~pat(a) ^ DW'(be * 16'h1234);
        access(1, AW'(a), nd, 2'(be), r);
        if (be[0]) shadow[a][7:0]  = nd[7:0];
        if (be[1]) shadow[a][15:8] = nd[15:8];
        access(0, AW'(a), '0, 2'(a % 4), r);
        check(r == lanes(shadow[a], 2'(a % 4)), "R3", "R5 lane-masked read", r,
              lanes(shadow[a], 2'(a % 4)));
      end
    end
    // Final readback of every word
    for (int a = 0; a < (1<<AW); a++) begin
      access(0, AW'(a), '0, 2'b11, r);
      check(r == shadow[a], "R3", "final readback", r, shadow[a]);
    end
    repeat (4) @(negedge clk);
    check(rsp_count == n_reads, "R5", "response count", rsp_count, n_reads);
    check(viol == 0, "R6", "model timing and contention violations", viol, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule